// File: doc/BRIEF.md
# Configuration Load Sequencer

This block walks a programmable logic fabric through loading a configuration image. Software sets up a control word over a 32-bit register port. Asserting the configuration pull while the master enable is on forces the fabric into reset. Releasing the pull lets the fabric enter its configuration phase. Image words then arrive on a separate write-only data port. They go out to the fabric only while the transfer enable is set, either 16 or 32 bits wide, and each word is held for a programmable number of fabric clocks.

When the fabric raises both its done and status inputs, the sequencer enters an initialisation phase. It issues a fixed burst of extra clocks and then reports user mode. If the status input falls during configuration, the sequencer drops back to reset and latches an error flag. The flag holds the sequencer in reset until software asserts the pull again.

Top module: `cfg_loader_ctrl`

## Requirements
- R1: After reset the mode field is 0 (power-up), the control word reads 0x2, the error flag is 0, `fab_cfg_n` is 1 and `dat_ready` is 1.
- R2: The register at byte offset 0x0 (status) reads the mode in bits [2:0] (0 power-up, 1 reset, 2 configuration, 3 initialisation, 4 user; code 5 is reserved for unknown). Bits [7:3] hold `strap_sel`, bit 8 holds the error flag and the other bits read 0.
- R3: The register at offset 0x4 (control) stores and reads back bit 0 master enable, bit 1 active-low chip enable (driven on `fab_ce_n`), bit 2 configuration pull, bits [7:6] ratio code, bit 8 transfer enable and bit 9 wide select. Other bits read 0, and any other offset reads 0.
- R4: While the master enable and the pull are both 1, the mode becomes 1 (reset) and `fab_cfg_n` is driven low.
- R5: With the pull released and no error latched, a mode of 1 advances to 2 (configuration).
- R6: In configuration, `fab_done` and `fab_status` both high move the mode to 3. `fab_xclk` is then high for exactly EXTRA_CLKS (4) cycles, after which the mode is 4 (user).
- R7: `fab_status` low in configuration returns the mode to 1 and sets the error flag (`cfg_err`, status bit 8). The mode stays at 1 while the error is set and the pull is 0. Asserting the pull clears the error.
- R8: Data-port writes while the master enable or the transfer enable is 0 are dropped. `fab_vld` stays 0 and `dat_ready` stays 1.
- R9: With wide select 1 the full 32-bit word is forwarded. With wide select 0 the low 16 bits are forwarded and the upper 16 bits are 0.
- R10: With ratio code k, an accepted word is held on `fab_data` with `fab_vld` high for 2^k cycles. `dat_ready` is low for the 2^k-1 cycles after the accept.
- R11: With the master enable 0, the pull has no effect: `fab_cfg_n` stays 1 and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | DATA_W | Configuration image word |
| dat_ready | output | 1 | Low while an accepted word is still being held |
| strap_sel | input | STRAP_W | External mode-select straps |
| fab_done | input | 1 | Fabric done indication |
| fab_status | input | 1 | Fabric status indication (high is healthy) |
| fab_cfg_n | output | 1 | Active-low configuration pull to the fabric |
| fab_ce_n | output | 1 | Active-low chip enable to the fabric |
| fab_xclk | output | 1 | Extra clock enable during initialisation |
| fab_data | output | DATA_W | Word forwarded to the fabric |
| fab_vld | output | 1 | `fab_data` is valid |
| cfg_err | output | 1 | Latched configuration error |

## Verification
The assertions check several rules on every cycle: the pull forcing reset, a status loss leading to reset with the error set, initialisation being entered only from configuration, gated writes leaving the output idle, held words staying stable, and the narrow mode clearing the upper half. The bench scenarios are needed to show the complete load sequence, which includes the exact count of extra clocks before user mode and the error staying sticky until the pull is asserted again. They also cover register readback and layout, and the hold length for each ratio code in both widths.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    M_PWRUP   = 3'd0,
    M_RESET   = 3'd1,
    M_CONFIG  = 3'd2,
    M_INIT    = 3'd3,
    M_USER    = 3'd4,
    M_UNKNOWN = 3'd5
  } mode_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_CEN  = 1;
  localparam int CTL_PULL = 2;
  localparam int CTL_RLO  = 6;
  localparam int CTL_XFER = 8;
  localparam int CTL_WIDE = 9;

  typedef struct packed {
    logic       wide;
    logic       xfer;
    logic [1:0] ratio;
    logic       pull;
    logic       ce_n;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/cfgl_regs.sv
module cfgl_regs
  import cfgl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int STRAP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  mode_e             mode,
  input  logic [STRAP_W-1:0] strap,
  input  logic              err,
  output logic [31:0]       rdata,
  output ctl_t              ctl
);
  localparam int WIDX_W   = ADDR_W - 2;
  localparam int ERR_BIT  = 3 + STRAP_W;

  logic [WIDX_W-1:0] widx;
  logic              sel_stat, sel_ctl;
  logic [31:0]       stat_word, ctl_word, rd_mux;

  assign widx     = addr[ADDR_W-1:2];
  assign sel_stat = (widx == WIDX_W'(0));
  assign sel_ctl  = (widx == WIDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '{wide: 1'b0, xfer: 1'b0, ratio: 2'd0, pull: 1'b0, ce_n: 1'b1, en: 1'b0};
    end else if (wr && sel_ctl) begin
      ctl.en    <= wdata[CTL_EN];
      ctl.ce_n  <= wdata[CTL_CEN];
      ctl.pull  <= wdata[CTL_PULL];
      ctl.ratio <= wdata[CTL_RLO +: 2];
      ctl.xfer  <= wdata[CTL_XFER];
      ctl.wide  <= wdata[CTL_WIDE];
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[2:0]           = mode;
    stat_word[3 +: STRAP_W]  = strap;
    stat_word[ERR_BIT]       = err;
    ctl_word = '0;
    ctl_word[CTL_EN]         = ctl.en;
    ctl_word[CTL_CEN]        = ctl.ce_n;
    ctl_word[CTL_PULL]       = ctl.pull;
    ctl_word[CTL_RLO +: 2]   = ctl.ratio;
    ctl_word[CTL_XFER]       = ctl.xfer;
    ctl_word[CTL_WIDE]       = ctl.wide;
    if (sel_stat)     rd_mux = stat_word;
    else if (sel_ctl) rd_mux = ctl_word;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R3: a control write is visible in the stored fields on the next cycle
  a_r3_ctl_write: assert property (@(posedge clk) disable iff (rst)
    (wr && sel_ctl) |=> (ctl.pull == $past(wdata[CTL_PULL]) && ctl.en == $past(wdata[CTL_EN])));
endmodule

// File: rtl/cfgl_mode_fsm.sv
module cfgl_mode_fsm
  import cfgl_pkg::*;
#(
  parameter int EXTRA_CLKS = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  pull,
  input  logic  fab_done,
  input  logic  fab_status,
  output mode_e mode,
  output logic  err,
  output logic  cfg_n,
  output logic  xclk
);
  localparam int CNT_W = $clog2(EXTRA_CLKS + 1);

  logic [CNT_W-1:0] xcnt;
  logic             hold_rst;

  assign hold_rst = en & pull;
  assign xclk     = (mode == M_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= M_PWRUP;
      err   <= 1'b0;
      xcnt  <= '0;
      cfg_n <= 1'b1;
    end else begin
      cfg_n <= ~hold_rst;
      if (hold_rst) begin
        mode <= M_RESET;
        err  <= 1'b0;
        xcnt <= '0;
      end else begin
        case (mode)
          M_RESET:  if (!err) mode <= M_CONFIG;
          M_CONFIG: begin
            if (!fab_status) begin
              mode <= M_RESET;
              err  <= 1'b1;
            end else if (fab_done) begin
              mode <= M_INIT;
              xcnt <= '0;
            end
          end
          M_INIT: begin
            if (xcnt == CNT_W'(EXTRA_CLKS - 1)) mode <= M_USER;
            else                                xcnt <= xcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: pull with enable forces reset mode
  a_r4_pull_forces_reset: assert property (@(posedge clk) disable iff (rst)
    (en && pull) |=> (mode == M_RESET && !cfg_n));
  // R7: status loss during configuration returns to reset and latches the error
  a_r7_status_loss: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CONFIG && !(en && pull) && !fab_status) |=> (mode == M_RESET && err));
  // R7: latched error keeps the sequencer in reset while the pull is off
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && mode == M_RESET && !(en && pull)) |=> (mode == M_RESET && err));
  // R6: initialisation is entered only from configuration
  a_r6_init_from_cfg: assert property (@(posedge clk) disable iff (rst)
    $rose(mode == M_INIT) |-> ($past(mode) == M_CONFIG));
  // R11: without the master enable the pull output stays released
  a_r11_no_en_no_pull: assert property (@(posedge clk) disable iff (rst)
    !en |=> cfg_n);
endmodule

// File: rtl/cfgl_data_path.sv
module cfgl_data_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              en,
  input  logic              xfer,
  input  logic              wide,
  input  logic [1:0]        ratio,
  output logic              dat_ready,
  output logic [DATA_W-1:0] fab_data,
  output logic              fab_vld
);
  localparam int HALF   = DATA_W / 2;
  localparam int RCNT_W = 3;

  logic [RCNT_W-1:0] hcnt;
  logic              gate, busy, accept;

  assign gate      = en & xfer;
  assign busy      = (hcnt != '0);
  assign dat_ready = !(gate && busy);
  assign accept    = dat_wr && gate && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt     <= '0;
      fab_vld  <= 1'b0;
      fab_data <= '0;
    end else if (accept) begin
      hcnt     <= RCNT_W'((4'd1 << ratio) - 4'd1);
      fab_vld  <= 1'b1;
      fab_data <= wide ? dat_wdata : {{(DATA_W-HALF){1'b0}}, dat_wdata[HALF-1:0]};
    end else if (busy) begin
      hcnt     <= hcnt - 1'b1;
    end else begin
      fab_vld  <= 1'b0;
    end
  end

  // R8: gated and idle means nothing reaches the fabric
  a_r8_gated_idle: assert property (@(posedge clk) disable iff (rst)
    (!gate && !busy) |=> !fab_vld);
  // R10: a held word stays stable and valid
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(fab_data) && fab_vld));
  // R9: narrow mode clears the upper half
  a_r9_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    (accept && !wide) |=> (fab_data[DATA_W-1:HALF] == '0));
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfgl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int STRAP_W    = 5,
  parameter int EXTRA_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               dat_wr,
  input  logic [DATA_W-1:0]  dat_wdata,
  output logic               dat_ready,
  input  logic [STRAP_W-1:0] strap_sel,
  input  logic               fab_done,
  input  logic               fab_status,
  output logic               fab_cfg_n,
  output logic               fab_ce_n,
  output logic               fab_xclk,
  output logic [DATA_W-1:0]  fab_data,
  output logic               fab_vld,
  output logic               cfg_err
);
  ctl_t  ctl;
  mode_e mode;
  logic  err;

  cfgl_regs #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .mode(mode), .strap(strap_sel), .err(err),
    .rdata(reg_rdata), .ctl(ctl)
  );

  cfgl_mode_fsm #(.EXTRA_CLKS(EXTRA_CLKS)) u_fsm (
    .clk(clk), .rst(rst), .en(ctl.en), .pull(ctl.pull),
    .fab_done(fab_done), .fab_status(fab_status),
    .mode(mode), .err(err), .cfg_n(fab_cfg_n), .xclk(fab_xclk)
  );

  cfgl_data_path #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .en(ctl.en), .xfer(ctl.xfer), .wide(ctl.wide), .ratio(ctl.ratio),
    .dat_ready(dat_ready), .fab_data(fab_data), .fab_vld(fab_vld)
  );

  assign fab_ce_n = ctl.ce_n;
  assign cfg_err  = err;
endmodule

// File: tb/test_cfg_loader_ctrl.sv
module test_cfg_loader_ctrl;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [2:0] MD_PWRUP = 3'd0, MD_RESET = 3'd1, MD_CFG = 3'd2,
                         MD_INIT = 3'd3, MD_USER = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, dat_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [DW-1:0] dat_wdata = '0, fab_data;
  logic dat_ready, fab_cfg_n, fab_ce_n, fab_xclk, fab_vld, cfg_err;
  logic [4:0] strap_sel = 5'h13;
  logic fab_done = 0, fab_status = 1;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  cfg_loader_ctrl i_cfg_loader_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_ready(dat_ready), .strap_sel(strap_sel), .fab_done(fab_done),
    .fab_status(fab_status), .fab_cfg_n(fab_cfg_n), .fab_ce_n(fab_ce_n),
    .fab_xclk(fab_xclk), .fab_data(fab_data), .fab_vld(fab_vld), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_status(logic [2:0] m, logic [4:0] s, logic e);
    return {23'd0, e, s, m};
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] w, logic wide);
    return wide ? w : {16'd0, w[15:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(logic [31:0] w, output int vlen, output int rlow,
                           output logic [31:0] got);
    @(negedge clk); dat_wr = 1; dat_wdata = w;
    @(negedge clk); dat_wr = 0;
    vlen = 0; rlow = 0; got = '0;
    for (int i = 0; i < 12; i++) begin
      if (fab_vld) begin
        if (vlen == 0) got = fab_data;
        vlen++;
      end
      if (!dat_ready) rlow++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, got, w;
    int vlen, rlow, xc, seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg_n", fab_cfg_n, 1);
    check("R1 ready", dat_ready, 1);
    check("R1 err", cfg_err, 0);
    reg_read(4'h4, rd); check("R1 ctl reset value", rd, 32'h2);
    // R2 status layout
    reg_read(4'h0, rd); check("R2 status after reset", rd, exp_status(MD_PWRUP, 5'h13, 0));
    strap_sel = 5'($urandom);
    reg_read(4'h0, rd); check("R2 strap field", rd, exp_status(MD_PWRUP, strap_sel, 0));
    // R3 control readback, unused bits, other offsets
    reg_write(4'h4, 32'hFFFF_FC38);
    reg_read(4'h4, rd); check("R3 unused ctl bits", rd, 32'h0);
    check("R3 ce_n follows bit1", fab_ce_n, 0);
    reg_write(4'h4, 32'h0000_02C2);
    reg_read(4'h4, rd); check("R3 ctl readback", rd, 32'h2C2);
    reg_read(4'h8, rd); check("R3 other offset", rd, 32'h0);

    // R11 pull without enable
    reg_write(4'h4, 32'h6);
    idle(3);
    check("R11 cfg_n stays high", fab_cfg_n, 1);
    reg_read(4'h0, rd); check("R11 mode unchanged", rd[2:0], MD_PWRUP);

    // R4 pull with enable
    reg_write(4'h4, 32'h5);
    idle(3);
    check("R4 cfg_n low", fab_cfg_n, 0);
    reg_read(4'h0, rd); check("R4 mode reset", rd[2:0], MD_RESET);

    // R5 release
    reg_write(4'h4, 32'h1);
    idle(3);
    check("R5 cfg_n high", fab_cfg_n, 1);
    reg_read(4'h0, rd); check("R5 mode config", rd[2:0], MD_CFG);

    // R8 dropped writes: transfer off
    send_word(32'hDEAD_BEEF, vlen, rlow, got);
    check("R8 xfer off no vld", vlen, 0);
    check("R8 xfer off ready", rlow, 0);
    // R8 dropped writes: enable off, transfer on
    reg_write(4'h4, 32'h300);
    send_word(32'h1234_5678, vlen, rlow, got);
    check("R8 en off no vld", vlen, 0);
    check("R8 en off ready", rlow, 0);
    reg_write(4'h4, 32'h1);
    idle(2);
    reg_read(4'h0, rd); check("R8 still config", rd[2:0], MD_CFG);

    // R9/R10 ratio and width sweep with random words
    for (int r = 0; r < 4; r++) begin
      for (int wd = 0; wd < 2; wd++) begin
        reg_write(4'h4, 32'h101 | (32'(r) << 6) | (32'(wd) << 9));
        for (int k = 0; k < 3; k++) begin
          w = $urandom;
          send_word(w, vlen, rlow, got);
          check($sformatf("R9 data r=%0d wide=%0d", r, wd), got, exp_word(w, wd[0]));
          check($sformatf("R10 hold r=%0d", r), vlen, 1 << r);
          check($sformatf("R10 ready low r=%0d", r), rlow, (1 << r) - 1);
        end
      end
    end
    reg_write(4'h4, 32'h1);

    // R6 done and status high: init with extra clocks, then user
    @(negedge clk); fab_done = 1;
    xc = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (fab_xclk) xc++;
    end
    check("R6 extra clock count", xc, 4);
    reg_read(4'h0, rd); check("R6 user mode", rd, exp_status(MD_USER, strap_sel, 0));

    // R7 status loss
    reg_write(4'h4, 32'h5);
    fab_done = 0;
    reg_write(4'h4, 32'h1);
    idle(2);
    reg_read(4'h0, rd); check("R7 back in config", rd[2:0], MD_CFG);
    @(negedge clk); fab_status = 0;
    idle(2);
    check("R7 cfg_err set", cfg_err, 1);
    reg_read(4'h0, rd); check("R7 status err", rd, exp_status(MD_RESET, strap_sel, 1));
    fab_status = 1;
    idle(5);
    reg_read(4'h0, rd); check("R7 sticky reset", rd, exp_status(MD_RESET, strap_sel, 1));
    reg_write(4'h4, 32'h5);
    idle(2);
    check("R7 err cleared by pull", cfg_err, 0);
    reg_write(4'h4, 32'h1);
    idle(2);
    reg_read(4'h0, rd); check("R7 reconfig after clear", rd, exp_status(MD_CFG, strap_sel, 0));

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule